// File: doc/BRIEF.md
# Masked interrupt request aggregator

This block collects up to eight device interrupt requests into a pending register and drives a single level-sensitive request line toward the host whenever at least one pending request is enabled. Devices set pending bits through a post vector and remove them through a clear vector. The host reaches the block through a small byte-wide port map. It can write a mask, read back that mask and the pending register, and acknowledge a single request by number.

The host writes the primary mask with ones meaning "masked", and the block stores the complement as its enable set. A secondary controller's mask is also kept so that software can read it back. That secondary mask never raises the request line, its status reads as zero, and acknowledges sent to it are dropped. The request line is registered. It is updated on the same clock edge as the pending and enable registers, so it always agrees with the stored state.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is held and after its release, pending is 0x00, the enable set is 0x00 (so address 0 reads 0xFF), the secondary mask reads 0x00 and `irq_o` is low.
- R2: A write to address 0 stores the complement of `wr_data` as the enable set, and reading address 0 returns the complement of the enable set (the last byte written).
- R3: Each bit set in `post_vec` on a clock edge sets the matching pending bit on that edge.
- R4: Each bit set in `clr_vec` clears the matching pending bit on that edge, and a clear wins over a post of the same bit in the same cycle.
- R5: A write to address 4 with `wr_data[3:0]` in 0..7 clears pending bit number `wr_data[3:0]`, and `wr_data[7:4]` is ignored.
- R6: A write to address 4 with `wr_data[3:0]` in 8..15 clears no pending bit.
- R7: `irq_o` is high exactly when pending AND enable is nonzero. It changes on the same edge that changes either register.
- R8: Reading address 2 returns the pending register. Reading address 3 returns 0x00, and reading addresses 4 to 7 also returns 0x00.
- R9: A write to address 1 stores `wr_data` unchanged as the secondary mask, readable at address 1. It has no effect on the enable set or on `irq_o`.
- R10: A write to address 5 (secondary acknowledge) and writes to addresses 2, 3, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` and state |
| post_vec | input | 8 | Device request set vector |
| clr_vec | input | 8 | Device request clear vector |
| irq_o | output | 1 | Level request toward the host |

## Verification
The bench targets the cases where the acknowledge number falls outside the register. A design that decoded only three bits would wrongly clear bit `n-8` there. It also drives a clear and a post of the same bit in one cycle, where a design with the wrong priority leaves the bit pending and the line high. Secondary-mask writes of 0x00 are made while requests are pending; a design that merged the two masks would raise `irq_o`. Random interleavings of mask writes, posts and clears catch a request line that is not recomputed on one of the three paths, because such a line goes stale.

// File: rtl/irq_agg_pkg.sv
// Shared port map and strobe bundle for the interrupt aggregator.
// Assumes a 3-bit host address space with one byte per access.
package irq_agg_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        PORT_PMASK = 3'd0,
        PORT_SMASK = 3'd1,
        PORT_PSTAT = 3'd2,
        PORT_SSTAT = 3'd3,
        PORT_PACK  = 3'd4,
        PORT_SACK  = 3'd5,
        PORT_RSV6  = 3'd6,
        PORT_RSV7  = 3'd7
    } port_e;

    typedef struct packed {
        logic pmask_we;
        logic smask_we;
        logic pack_we;
    } wr_strobe_t;

endpackage

// File: rtl/irq_host_decode.sv
// Turns a host write into per-register strobes.
// Assumes at most one write per cycle; unknown or read-only ports yield no strobe.
module irq_host_decode
    import irq_agg_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_strobe_t        strobe
);

    // Decode the write address into one-hot strobes.
    always_comb begin
        strobe = '0;
        if (wr_en) begin
            case (port_e'(wr_addr))
                PORT_PMASK: strobe.pmask_we = 1'b1;
                PORT_SMASK: strobe.smask_we = 1'b1;
                PORT_PACK:  strobe.pack_we  = 1'b1;
                default:    strobe = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_pending_bank.sv
// Pending request register: device posts set bits, while device clears and
// host acknowledges remove them, and removal wins. Also exposes the next state.
// Assumes ack numbers at or above VEC_W address no bit.
module irq_pending_bank #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned ACK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] post_vec,
    input  logic [VEC_W-1:0] clr_vec,
    input  logic             ack_we,
    input  logic [ACK_W-1:0] ack_num,
    output logic [VEC_W-1:0] pend_d,
    output logic [VEC_W-1:0] pend_q
);

    logic [VEC_W-1:0] ack_hit;

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        // Match the acknowledge number against this bit position.
        assign ack_hit[i] = ack_we && (ack_num == ACK_W'(i));
        // Next value of this bit: set by post, removed by clear or ack.
        assign pend_d[i] = (pend_q[i] | post_vec[i]) & ~clr_vec[i] & ~ack_hit[i];
    end

    // Register the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R3
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vec != '0 && (post_vec & clr_vec) == '0 && !ack_we)
        |=> ((pend_q & $past(post_vec)) == $past(post_vec)));

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((pend_q & $past(clr_vec)) == '0));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack_num < ACK_W'(VEC_W)) |=> !pend_q[$past(ack_num)]);

    // R6
    ack_high_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack_num >= ACK_W'(VEC_W) && clr_vec == '0)
        |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/irq_mask_regs.sv
// Holds the primary enable set (stored as the complement of the written mask)
// and the raw secondary mask. Assumes the strobes are mutually exclusive.
module irq_mask_regs #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pmask_we,
    input  logic             smask_we,
    input  logic [VEC_W-1:0] wr_data,
    output logic [VEC_W-1:0] en_d,
    output logic [VEC_W-1:0] en_q,
    output logic [VEC_W-1:0] smask_q
);

    // Next enable set: complement of a primary mask write, else hold.
    assign en_d = pmask_we ? ~wr_data : en_q;

    // Register the enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Register the secondary mask exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n)        smask_q <= '0;
        else if (smask_we) smask_q <= wr_data;
    end

    // R2
    en_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmask_we |=> (en_q == ~$past(wr_data)));

    // R9
    smask_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pmask_we |=> $stable(en_q));

    // R9
    smask_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smask_we |=> (smask_q == $past(wr_data)));

endmodule

// File: rtl/irq_line_drive.sv
// Registers the request line from the next pending and enable values, so the
// line moves on the same edge as the state. Assumes both inputs are next-state.
module irq_line_drive #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] pend_d,
    input  logic [VEC_W-1:0] en_d,
    output logic             irq_q
);

    logic [VEC_W-1:0] live;

    assign live = pend_d & en_d;

    // Register whether any enabled request will be pending.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |live;
    end

endmodule

// File: rtl/irq_aggregator.sv
// Top level: a host byte port, device post and clear vectors, and one level
// request line. Assumes one host write per cycle and a combinational read path.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned ACK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [VEC_W-1:0]  rd_data,
    input  logic [VEC_W-1:0]  post_vec,
    input  logic [VEC_W-1:0]  clr_vec,
    output logic              irq_o
);

    wr_strobe_t       strobe;
    logic [VEC_W-1:0] pend_d, pend_q;
    logic [VEC_W-1:0] en_d, en_q, smask_q;

    irq_host_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strobe  (strobe)
    );

    irq_pending_bank #(.VEC_W(VEC_W), .ACK_W(ACK_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_vec (post_vec),
        .clr_vec  (clr_vec),
        .ack_we   (strobe.pack_we),
        .ack_num  (wr_data[ACK_W-1:0]),
        .pend_d   (pend_d),
        .pend_q   (pend_q)
    );

    irq_mask_regs #(.VEC_W(VEC_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .pmask_we (strobe.pmask_we),
        .smask_we (strobe.smask_we),
        .wr_data  (wr_data),
        .en_d     (en_d),
        .en_q     (en_q),
        .smask_q  (smask_q)
    );

    irq_line_drive #(.VEC_W(VEC_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_d (pend_d),
        .en_d   (en_d),
        .irq_q  (irq_o)
    );

    // Select the host read data by address.
    always_comb begin
        case (port_e'(rd_addr))
            PORT_PMASK: rd_data = ~en_q;
            PORT_SMASK: rd_data = smask_q;
            PORT_PSTAT: rd_data = pend_q;
            default:    rd_data = '0;
        endcase
    end

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(pend_q & en_q)));

    // R10
    sack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd5 && post_vec == '0 && clr_vec == '0)
        |=> $stable(pend_q));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && smask_q == '0 && !irq_o));

endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] post_vec = '0;
    logic [7:0] clr_vec = '0;
    logic       irq_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [7:0] m_pend = '0;
    logic [7:0] m_en = '0;
    logic [7:0] m_smask = '0;

    always #10 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .post_vec(post_vec), .clr_vec(clr_vec), .irq_o(irq_o)
    );

    function automatic logic [7:0] next_pend(logic [7:0] p, logic [7:0] po,
                                             logic [7:0] cl, logic we,
                                             logic [2:0] a, logic [7:0] d);
        logic [7:0] r;
        r = (p | po) & ~cl;
        if (we && a == 3'd4 && d[3:0] < 4'd8) r[d[2:0]] = 1'b0;
        return r;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Compare every readable port and the line against the model.
    task automatic check_all(string req);
        rd_addr = 3'd0; #1; chk({req, " R2 pmask"}, rd_data, ~m_en);
        rd_addr = 3'd1; #1; chk({req, " R9 smask"}, rd_data, m_smask);
        rd_addr = 3'd2; #1; chk({req, " R8 pending"}, rd_data, m_pend);
        rd_addr = 3'd3; #1; chk({req, " R8 sstat"}, rd_data, 8'h00);
        chk({req, " R7 irq"}, {7'd0, irq_o}, {7'd0, |(m_pend & m_en)});
    endtask

    // One cycle of stimulus applied after a rising edge, then model update and checks.
    task automatic step(logic we, logic [2:0] a, logic [7:0] d,
                        logic [7:0] po, logic [7:0] cl, string req);
        wr_en = we; wr_addr = a; wr_data = d; post_vec = po; clr_vec = cl;
        @(posedge clk); #1;
        m_pend = next_pend(m_pend, po, cl, we, a, d);
        if (we && a == 3'd0) m_en = ~d;
        if (we && a == 3'd1) m_smask = d;
        wr_en = 1'b0; post_vec = '0; clr_vec = '0;
        check_all(req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state while held
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after release");

        // R3 post with everything masked: pending set, line stays low
        step(1'b0, 3'd0, 8'h00, 8'hA5, 8'h00, "R3 post masked");
        // R2 unmask bits 0 and 2
        step(1'b1, 3'd0, 8'hFA, 8'h00, 8'h00, "R2 unmask");
        // R9 secondary mask write of 0x00 must not raise anything new
        step(1'b1, 3'd0, 8'hFF, 8'h00, 8'h00, "R2 mask all");
        step(1'b1, 3'd1, 8'h00, 8'h00, 8'h00, "R9 smask zero");
        step(1'b1, 3'd0, 8'h00, 8'hFF, 8'h00, "R7 all on");
        // R6 ack numbers 8..15 clear nothing
        for (int n = 8; n < 16; n++)
            step(1'b1, 3'd4, 8'(n), 8'h00, 8'h00, "R6 high ack");
        // R10 secondary ack and writes to read-only or reserved addresses
        step(1'b1, 3'd5, 8'h03, 8'h00, 8'h00, "R10 sack");
        step(1'b1, 3'd2, 8'h00, 8'h00, 8'h00, "R10 wr pstat");
        step(1'b1, 3'd6, 8'h00, 8'h00, 8'h00, "R10 wr rsv");
        // R5 ack each bit with junk upper nibble
        for (int n = 0; n < 8; n++)
            step(1'b1, 3'd4, {4'hC, 4'(n)}, 8'h00, 8'h00, "R5 ack");
        // R4 clear wins over post in the same cycle
        step(1'b0, 3'd0, 8'h00, 8'h3C, 8'h0C, "R4 clr vs post");
        step(1'b0, 3'd0, 8'h00, 8'h00, 8'h30, "R4 clr rest");
        // R8 other read addresses return zero
        for (int a = 4; a < 8; a++) begin
            rd_addr = 3'(a); #1;
            chk("R8 unused read", rd_data, 8'h00);
        end

        // Random mix of all operations
        for (int i = 0; i < 600; i++) begin
            logic [2:0] a;
            logic [7:0] d, po, cl;
            logic we;
            we = ($urandom % 3) != 0;
            a  = 3'($urandom % 8);
            d  = 8'($urandom);
            po = (($urandom % 2) != 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            cl = (($urandom % 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            step(we, a, d, po, cl, "R7 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule